// File: doc/BRIEF.md
# Multi-Word Pixel Unpacker with Mode Mixing

This block sits at the front of a display pixel path. Every rising clock edge it samples a 16-bit pixel word, an active-display flag and a mode-mix select. It turns the word stream into complete dots: either 8-bit palette indices or direct 24-bit RGB. Some formats need one word per dot. Some need two words per dot. Two formats deliver two dots per group: one of them packs two indices in one word, and the other packs two 24-bit dots in three words. Two mode codes, a primary and a secondary, are held at the block's edge. The mix select chooses between them at the start of each word group, so a line can switch format on the fly between formats that take the same number of words per dot.

Words are taken least-significant byte first. The first word sampled after the active-display flag rises always opens a new group. While the flag is low, the word phase is held at its start and no dot is issued. Results leave on two lanes. Lane 0 carries the first displayed dot and lane 1 carries the second, when there is one. Each lane has a valid bit and an index/direct flag.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset, both lane valid bits are 0 and all lane data outputs are 0.
- R2: When `blank_n` is sampled low, no lane is valid in the following cycle, and a partly gathered group is discarded. The first word sampled with `blank_n` high opens a new group.
- R3: Mode code 00h, and every code from 0Ah to FFh, gives one index dot per word: the low byte of the word, on lane 0, with `dot_is_idx[0]`=1. A lane carrying an index drives RGB 0, and a lane carrying RGB drives index 0. A result appears in the cycle after the word that completes it is sampled.
- R4: Code 02h gives one direct dot per word from bits 14:10 (R), 9:5 (G) and 4:0 (B). Code 03h gives one direct dot per word from bits 15:11 (R), 10:5 (G) and 4:0 (B). Each field sits at the top of its 8-bit channel, with the missing low bits 0. RGB output is {R[23:16], G[15:8], B[7:0]}.
- R5: For code 01h, a word with bit 15 set yields its low byte as an index dot. A word with bit 15 clear yields the direct dot of code 02h.
- R6: Code 04h takes two words per dot. The first word gives G (bits 15:8) and B (bits 7:0). The low byte of the second word gives R. Nothing is valid after the first word.
- R7: Code 05h yields two index dots per word: the low byte on lane 0 and the high byte on lane 1, both in the same cycle.
- R8: Codes 06h and 08h take two words and use only their low bytes (first byte b0, then b1). For 06h: B=b0[4:0], G={b1[2:0],b0[7:5]}, R=b1[7:3]. For 08h: B=b0[4:0], G={b1[1:0],b0[7:5]}, R=b1[6:2]. Missing low bits are 0.
- R9: Code 07h takes two words. The index is {second word bits 3:0, first word bits 3:0}.
- R10: Code 09h takes three words (w0, w1, w2) and issues two direct dots together after w2. Lane 0 is R=w1[7:0], G=w0[15:8], B=w0[7:0]. Lane 1 is R=w2[15:8], G=w2[7:0], B=w1[15:8].
- R11: `mix_sel` low selects the primary code and high selects the secondary code. It is sampled only with the first word of a group, so a change on a later word of that group has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_word | input | 16 | Pixel data word |
| blank_n | input | 1 | High during active display |
| mix_sel | input | 1 | 0 selects primary code, 1 selects secondary code |
| prim_code | input | 8 | Primary pixel format code |
| sec_code | input | 8 | Secondary pixel format code |
| dot_vld | output | 2 | Lane valid bits (bit 0 lane 0, bit 1 lane 1) |
| dot_is_idx | output | 2 | Per lane: 1 for palette index, 0 for direct RGB |
| dot0_idx | output | 8 | Lane 0 palette index |
| dot1_idx | output | 8 | Lane 1 palette index |
| dot0_rgb | output | 24 | Lane 0 direct colour {R,G,B} |
| dot1_rgb | output | 24 | Lane 1 direct colour {R,G,B} |

## Verification
A word is sampled on one rising edge, and a group's result is registered on that same edge. So the lanes show the dot made from a group's last word in the cycle after that word is driven, and they show it for exactly one cycle. Earlier words of a multi-word group must show no valid lane in their following cycles. The bench changes inputs one time unit after a rising edge and reads the lanes at that same moment, before the next edge. Each step therefore checks the result of the word driven in the step just before. A cycle with the active-display flag low separates the scenarios, so every scenario starts its first group on a known phase.

// File: rtl/pu_pkg.sv
package pu_pkg;

  localparam int WORD_W = 16;
  localparam int CH_W   = 8;
  localparam int RGB_W  = 3 * CH_W;
  localparam int CODE_W = 8;
  localparam int LANES  = 2;
  localparam int HOLD_N = 2;
  localparam int PH_W   = $clog2(HOLD_N + 1);

  typedef enum logic [3:0] {
    FMT_IDX8, FMT_MIX15, FMT_D15, FMT_D16, FMT_D24W,
    FMT_IDX8X2, FMT_D16B, FMT_IDX4B, FMT_D15B, FMT_D24PK
  } fmt_e;

  typedef struct packed {
    logic             vld;
    logic             is_idx;
    logic [CH_W-1:0]  idx;
    logic [RGB_W-1:0] rgb;
  } dot_t;

  function automatic fmt_e code_to_fmt(input logic [CODE_W-1:0] code);
    case (code)
      8'h01:   return FMT_MIX15;
      8'h02:   return FMT_D15;
      8'h03:   return FMT_D16;
      8'h04:   return FMT_D24W;
      8'h05:   return FMT_IDX8X2;
      8'h06:   return FMT_D16B;
      8'h07:   return FMT_IDX4B;
      8'h08:   return FMT_D15B;
      8'h09:   return FMT_D24PK;
      default: return FMT_IDX8;
    endcase
  endfunction

  function automatic logic [PH_W-1:0] words_per_group(input fmt_e f);
    case (f)
      FMT_D24W, FMT_D16B, FMT_IDX4B, FMT_D15B: return PH_W'(2);
      FMT_D24PK:                               return PH_W'(3);
      default:                                 return PH_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/pu_phase.sv
module pu_phase
  import pu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blank_n,
  input  logic              mix_sel,
  input  logic [CODE_W-1:0] prim_code,
  input  logic [CODE_W-1:0] sec_code,
  output logic [PH_W-1:0]   ph,
  output fmt_e              fmt,
  output logic              grp_last
);

  logic [PH_W-1:0] ph_q, ph_d, grp_len;
  fmt_e            fmt_q, fmt_d, sel_fmt;
  logic            open_grp;

  always_comb begin
    sel_fmt  = code_to_fmt(mix_sel ? sec_code : prim_code);
    open_grp = (ph_q == '0);
    fmt      = open_grp ? sel_fmt : fmt_q;
    grp_len  = words_per_group(fmt);
    grp_last = blank_n && (ph_q == grp_len - PH_W'(1));
    if (!blank_n || grp_last) ph_d = '0;
    else                      ph_d = ph_q + PH_W'(1);
    fmt_d = (blank_n && open_grp) ? sel_fmt : fmt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      fmt_q <= FMT_IDX8;
    end else begin
      ph_q  <= ph_d;
      fmt_q <= fmt_d;
    end
  end

  assign ph = ph_q;

endmodule

// File: rtl/pu_hold.sv
module pu_hold
  import pu_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           blank_n,
  input  logic [PH_W-1:0]                ph,
  input  logic [WORD_W-1:0]              word,
  output logic [HOLD_N-1:0][WORD_W-1:0]  held
);

  for (genvar i = 0; i < HOLD_N; i++) begin : g_slot
    logic              en;
    logic [WORD_W-1:0] q;
    assign en = blank_n && (ph == PH_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= word;
    end
    assign held[i] = q;
  end

endmodule

// File: rtl/pu_assemble.sv
module pu_assemble
  import pu_pkg::*;
(
  input  fmt_e                           fmt,
  input  logic                           grp_last,
  input  logic [HOLD_N-1:0][WORD_W-1:0]  held,
  input  logic [WORD_W-1:0]              word,
  output dot_t [LANES-1:0]               lanes
);

  logic [WORD_W-1:0] w0, w1;
  logic [CH_W-1:0]   b0, b1;

  function automatic logic [RGB_W-1:0] pack565(input logic [4:0] r,
                                                input logic [5:0] g,
                                                input logic [4:0] b);
    return {r, 3'b000, g, 2'b00, b, 3'b000};
  endfunction

  function automatic logic [RGB_W-1:0] pack555(input logic [4:0] r,
                                                input logic [4:0] g,
                                                input logic [4:0] b);
    return {r, 3'b000, g, 3'b000, b, 3'b000};
  endfunction

  always_comb begin
    w0 = held[0];
    w1 = held[1];
    b0 = w0[CH_W-1:0];
    b1 = word[CH_W-1:0];
    lanes = '0;
    case (fmt)
      FMT_MIX15: begin
        if (word[WORD_W-1]) begin
          lanes[0].is_idx = 1'b1;
          lanes[0].idx    = word[CH_W-1:0];
        end else begin
          lanes[0].rgb = pack555(word[14:10], word[9:5], word[4:0]);
        end
      end
      FMT_D15:  lanes[0].rgb = pack555(word[14:10], word[9:5], word[4:0]);
      FMT_D16:  lanes[0].rgb = pack565(word[15:11], word[10:5], word[4:0]);
      FMT_D24W: lanes[0].rgb = {word[CH_W-1:0], w0};
      FMT_IDX8X2: begin
        lanes[0].is_idx = 1'b1;
        lanes[0].idx    = word[CH_W-1:0];
        lanes[1].is_idx = 1'b1;
        lanes[1].idx    = word[WORD_W-1:CH_W];
      end
      FMT_D16B: lanes[0].rgb = pack565(b1[7:3], {b1[2:0], b0[7:5]}, b0[4:0]);
      FMT_IDX4B: begin
        lanes[0].is_idx = 1'b1;
        lanes[0].idx    = {b1[3:0], b0[3:0]};
      end
      FMT_D15B: lanes[0].rgb = pack555(b1[6:2], {b1[1:0], b0[7:5]}, b0[4:0]);
      FMT_D24PK: begin
        lanes[0].rgb = {w1[CH_W-1:0], w0};
        lanes[1].rgb = {word, w1[WORD_W-1:CH_W]};
      end
      default: begin
        lanes[0].is_idx = 1'b1;
        lanes[0].idx    = word[CH_W-1:0];
      end
    endcase
    lanes[0].vld = grp_last;
    lanes[1].vld = grp_last && (fmt == FMT_IDX8X2 || fmt == FMT_D24PK);
  end

endmodule

// File: rtl/pu_outreg.sv
module pu_outreg
  import pu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  dot_t [LANES-1:0] d_in,
  output dot_t [LANES-1:0] q_out
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    dot_t nxt, cur;
    always_comb begin
      nxt     = cur;
      nxt.vld = d_in[i].vld;
      if (d_in[i].vld) nxt = d_in[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= '0;
      else        cur <= nxt;
    end
    assign q_out[i] = cur;
  end

endmodule

// File: rtl/pixel_unpacker.sv
module pixel_unpacker
  import pu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] pix_word,
  input  logic              blank_n,
  input  logic              mix_sel,
  input  logic [CODE_W-1:0] prim_code,
  input  logic [CODE_W-1:0] sec_code,
  output logic [LANES-1:0]  dot_vld,
  output logic [LANES-1:0]  dot_is_idx,
  output logic [CH_W-1:0]   dot0_idx,
  output logic [CH_W-1:0]   dot1_idx,
  output logic [RGB_W-1:0]  dot0_rgb,
  output logic [RGB_W-1:0]  dot1_rgb
);

  logic rst_meta, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [PH_W-1:0]               ph_q;
  fmt_e                          grp_fmt;
  logic                          grp_last;
  logic [HOLD_N-1:0][WORD_W-1:0] held;
  dot_t [LANES-1:0]              lanes_d, lanes_q;

  pu_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .blank_n  (blank_n),
    .mix_sel  (mix_sel),
    .prim_code(prim_code),
    .sec_code (sec_code),
    .ph       (ph_q),
    .fmt      (grp_fmt),
    .grp_last (grp_last)
  );

  pu_hold u_hold (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .blank_n(blank_n),
    .ph     (ph_q),
    .word   (pix_word),
    .held   (held)
  );

  pu_assemble u_asm (
    .fmt     (grp_fmt),
    .grp_last(grp_last),
    .held    (held),
    .word    (pix_word),
    .lanes   (lanes_d)
  );

  pu_outreg u_out (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d_in (lanes_d),
    .q_out(lanes_q)
  );

  assign dot_vld    = {lanes_q[1].vld,    lanes_q[0].vld};
  assign dot_is_idx = {lanes_q[1].is_idx, lanes_q[0].is_idx};
  assign dot0_idx   = lanes_q[0].idx;
  assign dot1_idx   = lanes_q[1].idx;
  assign dot0_rgb   = lanes_q[0].rgb;
  assign dot1_rgb   = lanes_q[1].rgb;

endmodule

// File: rtl/pu_chk.sv
module pu_chk
  import pu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              blank_n,
  input logic [PH_W-1:0]   ph,
  input logic [LANES-1:0]  dot_vld,
  input logic [LANES-1:0]  dot_is_idx,
  input logic [CH_W-1:0]   dot0_idx,
  input logic [CH_W-1:0]   dot1_idx,
  input logic [RGB_W-1:0]  dot0_rgb,
  input logic [RGB_W-1:0]  dot1_rgb
);

  // R2
  blank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> dot_vld == '0);

  // R2
  blank_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> ph == '0);

  // R7
  lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dot_vld[1] |-> dot_vld[0]);

  // R3
  idx_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_vld[0] && dot_is_idx[0]) |-> dot0_rgb == '0);

  // R3
  rgb_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_vld[0] && !dot_is_idx[0]) |-> dot0_idx == '0);

  // R10
  lane1_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_vld[1] && !dot_is_idx[1]) |-> (dot1_idx == '0 && !dot_is_idx[0]));

  // R7
  lane1_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_vld[1] && dot_is_idx[1]) |-> (dot1_rgb == '0 && dot_is_idx[0]));

endmodule

bind pixel_unpacker pu_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .blank_n   (blank_n),
  .ph        (ph_q),
  .dot_vld   (dot_vld),
  .dot_is_idx(dot_is_idx),
  .dot0_idx  (dot0_idx),
  .dot1_idx  (dot1_idx),
  .dot0_rgb  (dot0_rgb),
  .dot1_rgb  (dot1_rgb)
);

// File: tb/tb_pixel_unpacker.sv
`timescale 1ns/1ps
module tb_pixel_unpacker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pix_word;
  logic        blank_n, mix_sel;
  logic [7:0]  prim_code, sec_code;
  logic [1:0]  dot_vld, dot_is_idx;
  logic [7:0]  dot0_idx, dot1_idx;
  logic [23:0] dot0_rgb, dot1_rgb;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pixel_unpacker dut (
    .clk(clk), .rst_n(rst_n), .pix_word(pix_word), .blank_n(blank_n),
    .mix_sel(mix_sel), .prim_code(prim_code), .sec_code(sec_code),
    .dot_vld(dot_vld), .dot_is_idx(dot_is_idx), .dot0_idx(dot0_idx),
    .dot1_idx(dot1_idx), .dot0_rgb(dot0_rgb), .dot1_rgb(dot1_rgb)
  );

  task automatic step(input logic [15:0] w, input logic b, input logic m);
    pix_word = w; blank_n = b; mix_sel = m;
    @(posedge clk); #1;
  endtask

  task automatic gap();
    step(16'h0000, 1'b0, 1'b0);
  endtask

  task automatic cmp(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic chk_none(input string rq);
    cmp(rq, "valid", 32'(dot_vld), 32'h0);
  endtask

  task automatic chk_idx(input string rq, input logic [7:0] i0,
                         input bit two, input logic [7:0] i1);
    cmp(rq, "valid", 32'(dot_vld), two ? 32'h3 : 32'h1);
    cmp(rq, "lane0 index", {dot_is_idx[0], dot0_idx, dot0_rgb[0]}, {1'b1, i0, 1'b0});
    if (two) cmp(rq, "lane1 index", {dot_is_idx[1], dot1_idx}, {1'b1, i1});
  endtask

  task automatic chk_rgb(input string rq, input logic [23:0] c0,
                         input bit two, input logic [23:0] c1);
    cmp(rq, "valid", 32'(dot_vld), two ? 32'h3 : 32'h1);
    cmp(rq, "lane0 rgb", {dot_is_idx[0], dot0_rgb}, {1'b0, c0});
    cmp(rq, "lane0 idx", 32'(dot0_idx), 32'h0);
    if (two) cmp(rq, "lane1 rgb", {dot_is_idx[1], dot1_rgb}, {1'b0, c1});
  endtask

  task automatic t_reset();
    // R1
    cmp("R1", "valid", 32'(dot_vld), 32'h0);
    cmp("R1", "data", {dot0_idx, dot0_rgb}, 32'h0);
    cmp("R1", "lane1 data", {dot1_idx, dot1_rgb}, 32'h0);
  endtask

  task automatic t_idx8();
    // R3
    prim_code = 8'h00; gap();
    step(16'hAB5C, 1, 0); chk_idx("R3", 8'h5C, 0, 0);
    step(16'h10FE, 1, 0); chk_idx("R3", 8'hFE, 0, 0);
    prim_code = 8'h3F; gap();
    step(16'h77C3, 1, 0); chk_idx("R3", 8'hC3, 0, 0);
    prim_code = 8'h0A; gap();
    step(16'h0011, 1, 0); chk_idx("R3", 8'h11, 0, 0);
  endtask

  task automatic t_direct1();
    // R4
    logic [4:0] r = 5'h15, b = 5'h1F;
    logic [5:0] g6 = 6'h2A;
    logic [4:0] g5 = 5'h0A;
    prim_code = 8'h02; gap();
    step({1'b1, r, g5, b}, 1, 0);
    chk_rgb("R4", {r, 3'b0, g5, 3'b0, b, 3'b0}, 0, 0);
    prim_code = 8'h03; gap();
    step({r, g6, b}, 1, 0);
    chk_rgb("R4", {r, 3'b0, g6, 2'b0, b, 3'b0}, 0, 0);
  endtask

  task automatic t_mixed();
    // R5
    prim_code = 8'h01; gap();
    step(16'h80A7, 1, 0); chk_idx("R5", 8'hA7, 0, 0);
    step({1'b0, 5'h11, 5'h06, 5'h19}, 1, 0);
    chk_rgb("R5", {5'h11, 3'b0, 5'h06, 3'b0, 5'h19, 3'b0}, 0, 0);
  endtask

  task automatic t_two_word24();
    // R6
    prim_code = 8'h04; gap();
    step(16'h3C5A, 1, 0); chk_none("R6");
    step(16'hEE96, 1, 0); chk_rgb("R6", 24'h963C5A, 0, 0);
    step(16'h0102, 1, 0); chk_none("R6");
    step(16'h9903, 1, 0); chk_rgb("R6", 24'h030102, 0, 0);
  endtask

  task automatic t_double_idx();
    // R7
    prim_code = 8'h05; gap();
    step(16'h12F0, 1, 0); chk_idx("R7", 8'hF0, 1, 8'h12);
    step(16'hC381, 1, 0); chk_idx("R7", 8'h81, 1, 8'hC3);
  endtask

  task automatic t_byte_pairs();
    // R8
    logic [4:0] r = 5'h1B, b = 5'h05;
    logic [5:0] g6 = 6'h35;
    logic [4:0] g5 = 5'h13;
    prim_code = 8'h06; gap();
    step({8'hEE, g6[2:0], b}, 1, 0); chk_none("R8");
    step({8'hDD, r, g6[5:3]}, 1, 0);
    chk_rgb("R8", {r, 3'b0, g6, 2'b0, b, 3'b0}, 0, 0);
    prim_code = 8'h08; gap();
    step({8'h55, g5[2:0], b}, 1, 0); chk_none("R8");
    step({8'hAA, 1'b1, r, g5[4:3]}, 1, 0);
    chk_rgb("R8", {r, 3'b0, g5, 3'b0, b, 3'b0}, 0, 0);
  endtask

  task automatic t_nibbles();
    // R9
    prim_code = 8'h07; gap();
    step(16'hFFF6, 1, 0); chk_none("R9");
    step(16'h00A9, 1, 0); chk_idx("R9", 8'h96, 0, 0);
  endtask

  task automatic t_packed24();
    // R10
    prim_code = 8'h09; gap();
    step(16'h2211, 1, 0); chk_none("R10");
    step(16'h4433, 1, 0); chk_none("R10");
    step(16'h6655, 1, 0); chk_rgb("R10", 24'h332211, 1, 24'h665544);
    step(16'hB0A0, 1, 0); chk_none("R10");
    step(16'hD0C0, 1, 0); chk_none("R10");
    step(16'hF0E0, 1, 0); chk_rgb("R10", 24'hC0B0A0, 1, 24'hF0E0D0);
  endtask

  task automatic t_blank_realign();
    // R2
    prim_code = 8'h04; gap();
    step(16'h1111, 1, 0); chk_none("R2");
    step(16'h2222, 0, 0); chk_none("R2");
    step(16'hBEEF, 1, 0); chk_none("R2");
    step(16'h0042, 1, 0); chk_rgb("R2", 24'h42BEEF, 0, 0);
  endtask

  task automatic t_mix_select();
    // R11
    prim_code = 8'h00; sec_code = 8'h05; gap();
    step(16'h1234, 1, 1); chk_idx("R11", 8'h34, 1, 8'h12);
    step(16'h5678, 1, 0); chk_idx("R11", 8'h78, 0, 0);
    prim_code = 8'h04; sec_code = 8'h06; gap();
    step(16'h3C5A, 1, 0); chk_none("R11");
    step(16'h0096, 1, 1); chk_rgb("R11", 24'h963C5A, 0, 0);
    step({8'h00, 3'b101, 5'h05}, 1, 1); chk_none("R11");
    step({8'h00, 5'h1B, 3'b110}, 1, 0);
    chk_rgb("R11", {5'h1B, 3'b0, 6'b110101, 2'b0, 5'h05, 3'b0}, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0; pix_word = '0; blank_n = 1'b0; mix_sel = 1'b0;
    prim_code = 8'h00; sec_code = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_idx8();
    t_direct1();
    t_mixed();
    t_two_word24();
    t_double_idx();
    t_byte_pairs();
    t_nibbles();
    t_packed24();
    t_blank_realign();
    t_mix_select();
    gap();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule